// File: doc/BRIEF.md
# Framed Serial DAC Command Receiver

This block sits between a host serial port and the digital side of a 12-bit voltage-output converter. The host sends 16-bit command words over a data line and a serial clock, framed by a frame-sync strobe and gated by an active-low chip select. The pins are sampled by a faster system clock through two-flop synchronisers, and all edge detection works on the synchronised samples. Each word is assembled most significant bit first. Once the word is complete, the block commits it to a 12-bit code latch and a 2-bit control latch.

Each word carries a code and two option bits. One option bit picks fast or slow output settling. The other powers the converter down. A power-down word leaves the stored code in place, so when an active word later brings the output back, the previously held level stays valid. The output-enable level drops while the converter is powered down. A single-cycle strobe marks every latch update.

Top module: `sdac_cmd_rx`

## Requirements
- R1: While the chip select input is high, serial clock and frame-sync activity shifts no bits and causes no latch update.
- R2: A frame opens only on a falling edge of frame-sync seen while chip select is low. Serial clock edges outside an open frame have no effect.
- R3: Inside an open frame, each falling serial-clock edge shifts the data line into a 16-bit word, most significant bit first. Word bits 11..0 form the 12-bit code.
- R4: After the 16th falling edge, nothing updates until the first rising edge of either the serial clock or frame-sync. That edge commits the word to the latches.
- R5: Word bit 14 drives the speed output: 1 gives fast settling and 0 gives slow settling.
- R6: Word bit 13 set to 1 selects power-down. Such a word updates only the speed and power-down latches, leaves the code unchanged, and drives out_enable low. Bit 13 set to 0 makes the block active and loads the code.
- R7: The code held before a power-down word is still presented on dac_code throughout power-down and after it.
- R8: Word bits 15 and 12 have no effect on any output.
- R9: Reset sets dac_code to 0, speed_fast to 0, power_down to 0 and out_enable to 1, with no update strobe.
- R10: A frame cut short, either by chip select rising or by a new frame-sync falling edge before 16 bits, is discarded with no update. A new falling edge of frame-sync starts a fresh frame.
- R11: A frame-sync rising edge after bit 16 commits the word as well as a serial-clock rising edge does.
- R12: update_pulse is high for exactly one system-clock cycle per committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_din | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edges |
| ser_cs_n | input | 1 | Active-low chip select; tie low for three-wire use |
| ser_fsync | input | 1 | Frame-sync strobe; falling edge opens a frame |
| dac_code | output | 12 | Latched converter code |
| speed_fast | output | 1 | 1 = fast settling, 0 = slow settling |
| power_down | output | 1 | 1 = converter powered down |
| out_enable | output | 1 | 1 while the converter output is driven |
| update_pulse | output | 1 | One-cycle strobe on each latch update |

## Verification
The assertions assume that every serial pin holds each level for several system-clock cycles. Each serial-clock phase and each frame-sync level must last long enough to pass both synchroniser stages before the next edge, and the data line must be stable around each falling serial-clock edge. The stimulus holds every pin change for five system clocks before the next one, and it changes data only while the serial clock is high. Under these conditions each pin edge yields one detected edge and one shifted bit. Both kinds of aborted frame are driven on purpose, along with update by frame-sync.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned SPD_BIT = 14;
  localparam int unsigned PD_BIT  = 13;
  localparam int unsigned SYNC_N  = 4;
  // pin index order inside the synchroniser bank
  localparam int unsigned PIN_DIN = 0;
  localparam int unsigned PIN_CLK = 1;
  localparam int unsigned PIN_CS  = 2;
  localparam int unsigned PIN_FS  = 3;

  typedef struct packed {
    logic fast;
    logic pdn;
  } ctrl_t;

  typedef enum logic {
    FR_IDLE  = 1'b0,
    FR_SHIFT = 1'b1
  } frame_st_t;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int unsigned        N       = 4,
  parameter logic [N-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
        prev_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= pins_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end

    always_comb begin
      lvl_o[g]  = sync_q[g];
      rise_o[g] = sync_q[g] & ~prev_q[g];
      fall_o[g] = ~sync_q[g] & prev_q[g];
    end
  end
endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter
  import sdac_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         fs_rise_i,
  input  logic         fs_fall_i,
  input  logic         cs_n_i,
  output logic         upd_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  frame_st_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W-1:0]     sh_q, sh_n;
  logic             sh_en;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_en = 1'b0;
    upd_o = 1'b0;
    if (cs_n_i) begin
      st_n  = FR_IDLE;
      cnt_n = '0;
    end else if (fs_fall_i) begin
      st_n  = FR_SHIFT;
      cnt_n = '0;
    end else if (st_q == FR_SHIFT) begin
      if (cnt_q == FULL) begin
        if (sclk_rise_i || fs_rise_i) begin
          upd_o = 1'b1;
          st_n  = FR_IDLE;
          cnt_n = '0;
        end
      end else if (sclk_fall_i) begin
        sh_en = 1'b1;
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb sh_n = {sh_q[W-2:0], din_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_n;
  end

  assign word_o = sh_q;

  assert_cnt_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  assert_cs_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (st_q == FR_IDLE && cnt_q == '0));

  assert_update_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> (cnt_q == '0));
endmodule

// File: rtl/sdac_latch_bank.sv
module sdac_latch_bank
  import sdac_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned CW      = 12,
  parameter int unsigned SPD_POS = 14,
  parameter int unsigned PD_POS  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic [W-1:0]  word_i,
  output logic [CW-1:0] code_o,
  output ctrl_t         ctrl_o,
  output logic          pulse_o
);
  logic [CW-1:0] code_q, code_n;
  logic          code_en;
  ctrl_t         ctrl_q, ctrl_n;

  always_comb begin
    ctrl_n.fast = word_i[SPD_POS];
    ctrl_n.pdn  = word_i[PD_POS];
    code_n      = word_i[CW-1:0];
    code_en     = upd_i & ~word_i[PD_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (upd_i) ctrl_q <= ctrl_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= upd_i;
  end

  assign code_o = code_q;
  assign ctrl_o = ctrl_q;

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(code_q));

  assert_pd_retain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && word_i[PD_POS]) |=> $stable(code_q));

  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_W,
  parameter int unsigned CODE_BITS = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_din,
  input  logic                 ser_clk,
  input  logic                 ser_cs_n,
  input  logic                 ser_fsync,
  output logic [CODE_BITS-1:0] dac_code,
  output logic                 speed_fast,
  output logic                 power_down,
  output logic                 out_enable,
  output logic                 update_pulse
);
  localparam logic [SYNC_N-1:0] PIN_IDLE = SYNC_N'(4'b1110);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [SYNC_N-1:0] pins, lvl, rise, fall;
  always_comb begin
    pins          = '0;
    pins[PIN_DIN] = ser_din;
    pins[PIN_CLK] = ser_clk;
    pins[PIN_CS]  = ser_cs_n;
    pins[PIN_FS]  = ser_fsync;
  end

  sdac_pin_sync #(.N(SYNC_N), .RST_VAL(PIN_IDLE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .pins_i (pins),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic                 upd;
  logic [WORD_BITS-1:0] word;

  sdac_frame_shifter #(.W(WORD_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .din_i       (lvl[PIN_DIN]),
    .sclk_rise_i (rise[PIN_CLK]),
    .sclk_fall_i (fall[PIN_CLK]),
    .fs_rise_i   (rise[PIN_FS]),
    .fs_fall_i   (fall[PIN_FS]),
    .cs_n_i      (lvl[PIN_CS]),
    .upd_o       (upd),
    .word_o      (word)
  );

  ctrl_t ctrl;

  sdac_latch_bank #(
    .W(WORD_BITS), .CW(CODE_BITS), .SPD_POS(SPD_BIT), .PD_POS(PD_BIT)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .upd_i   (upd),
    .word_i  (word),
    .code_o  (dac_code),
    .ctrl_o  (ctrl),
    .pulse_o (update_pulse)
  );

  assign speed_fast = ctrl.fast;
  assign power_down = ctrl.pdn;
  assign out_enable = ~ctrl.pdn;

  assert_ctrl_only_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    !update_pulse |-> $stable(speed_fast));
endmodule

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_din, ser_clk, ser_cs_n, ser_fsync;
  logic [11:0] dac_code;
  logic        speed_fast, power_down, out_enable, update_pulse;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int wide = 0;
  bit last_pulse = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdac_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
    .ser_cs_n(ser_cs_n), .ser_fsync(ser_fsync), .dac_code(dac_code),
    .speed_fast(speed_fast), .power_down(power_down),
    .out_enable(out_enable), .update_pulse(update_pulse)
  );

  always @(negedge clk) begin
    if (update_pulse) pulses++;
    if (update_pulse && last_pulse) wide++;
    last_pulse = update_pulse;
  end

  // {word, expected code, fast, pd, update by frame-sync, spare}
  localparam logic [31:0] VEC [0:8] = '{
    {16'h0ABC, 12'hABC, 4'b0000},  // R3 plain load
    {16'h4123, 12'h123, 4'b1010},  // R5 fast, R11 fsync update
    {16'h9FFF, 12'hFFF, 4'b0000},  // R8 bit15/bit12 ignored
    {16'h2555, 12'hFFF, 4'b0100},  // R6 power-down keeps code
    {16'h6000, 12'hFFF, 4'b1100},  // R7 code still held
    {16'h5800, 12'h800, 4'b1010},  // R6 release loads, R11
    {16'h0000, 12'h000, 4'b0000},  // R5 back to slow
    {16'hF001, 12'h000, 4'b1100},  // R8 with power-down
    {16'h0001, 12'h001, 4'b0000}   // R7 release
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ph();
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int n, input bit fs_up);
    int p0;
    p0 = pulses;
    ser_cs_n = 1'b0; ser_fsync = 1'b1; ser_clk = 1'b1; ph();
    ser_fsync = 1'b0; ph();
    for (int i = 0; i < n; i++) begin
      ser_din = w[15-i]; ph();
      ser_clk = 1'b0; ph();
      if (i != 15) begin ser_clk = 1'b1; ph(); end
    end
    if (n == 16) begin
      ph();
      chk("R4 no update before rising edge", pulses, p0);
      if (fs_up) begin ser_fsync = 1'b1; ph(); ser_clk = 1'b1; end
      else begin ser_clk = 1'b1; ph(); ser_fsync = 1'b1; end
      ph(); ph();
    end
  endtask

  initial begin
    int p;
    rst_n = 1'b0; ser_din = 1'b0; ser_clk = 1'b1; ser_cs_n = 1'b1; ser_fsync = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 code reset", dac_code, 0);
    chk("R9 speed reset", speed_fast, 0);
    chk("R9 pd reset", power_down, 0);
    chk("R9 oe reset", out_enable, 1);
    chk("R9 no pulse", pulses, 0);

    // R2: clocks with cs low but no frame-sync fall
    ser_cs_n = 1'b0; ser_din = 1'b1;
    for (int i = 0; i < 17; i++) begin ser_clk = 1'b0; ph(); ser_clk = 1'b1; ph(); end
    ph();
    chk("R2 no frame without fsync fall", pulses, 0);
    chk("R2 code unchanged", dac_code, 0);

    // R1: full frame with chip select high
    ser_cs_n = 1'b1; ser_fsync = 1'b0; ph();
    for (int i = 0; i < 16; i++) begin ser_clk = 1'b0; ph(); ser_clk = 1'b1; ph(); end
    ser_fsync = 1'b1; ph(); ph();
    chk("R1 cs high blocks update", pulses, 0);
    chk("R1 code unchanged", dac_code, 0);

    for (int v = 0; v < 9; v++) begin
      p = pulses;
      frame(VEC[v][31:16], 16, VEC[v][1]);
      chk("R3 R6 R7 code", dac_code, VEC[v][15:4]);
      chk("R5 speed", speed_fast, VEC[v][3]);
      chk("R6 power_down", power_down, VEC[v][2]);
      chk("R6 out_enable", out_enable, !VEC[v][2]);
      chk("R12 one pulse per word", pulses - p, 1);
    end

    // R10: abort by chip select
    p = pulses;
    frame(16'h0123, 10, 1'b0);
    ser_cs_n = 1'b1; ph();
    ser_clk = 1'b0; ph(); ser_clk = 1'b1; ph(); ser_fsync = 1'b1; ph(); ph();
    chk("R10 cs abort no pulse", pulses, p);
    chk("R10 cs abort code kept", dac_code, 12'h001);

    // R10: abort by a new frame-sync fall, then complete frame
    frame(16'h0777, 7, 1'b0);
    frame(16'h0456, 16, 1'b0);
    chk("R10 restart one pulse", pulses - p, 1);
    chk("R10 restart code", dac_code, 12'h456);

    // R9: reset after a power-down fast word
    frame(16'h6000, 16, 1'b0);
    chk("R7 code held in power-down", dac_code, 12'h456);
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (8) @(negedge clk);
    chk("R9 code cleared", dac_code, 0);
    chk("R9 speed slow", speed_fast, 0);
    chk("R9 active", {power_down, out_enable}, 2'b01);

    chk("R12 pulse width one cycle", wide, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule